// File: doc/BRIEF.md
# Reference Offset Calibration Engine

This block sits on the digital readout path of a column-parallel two-step ramp converter and removes the errors that mismatched reference levels put into each result. Every conversion delivers a coarse code `C` (which reference segment the input fell into) and a fine counter code `F`. One extra calibration column converts a known mid-segment test level. The test index `m` steps through `0..K-1` from one conversion to the next, so that column's coarse code is `K-1-m`.

The engine keeps a `K`-entry table, one entry per coarse code. Each entry holds the average of the calibration column's fine codes for that code. Results from the ordinary columns arrive one at a time. For each one, the engine reads the entry selected by its coarse code and produces

`F - T[C] + (K-C)*2^FINE_W - 2^(FINE_W-1)`

saturated to the output range. This cancels each reference's own offset and leaves only a constant shift.

Samples enter on a valid/ready stream, and a flag marks calibration samples. The corrected code appears on a registered output one cycle after acceptance. Until every table entry holds a finished average, the engine instead emits the plain two-step code `F - C*2^FINE_W` and flags it as uncorrected.

Top module: `offset_cal_engine`

## Requirements
- R1: While `rst` is high, `in_ready`, `out_valid` and `out_corrected` are 0. From the first clock after `rst` falls, `in_ready` is 1. Reset empties the table, so the next output is uncorrected.
- R2: A sample accepted with `in_cal`=0 on a clock edge gives `out_valid`=1 for exactly the following cycle. Samples accepted on consecutive edges give outputs on consecutive cycles. `out_valid` is never 1 otherwise.
- R3: A sample accepted with `in_cal`=1 gives no output: `out_valid` is 0 in the next cycle. It feeds the table entry whose index equals its `in_coarse` field (3 bits, unsigned). The calibration sequence `m`=0..K-1 therefore lands on entries K-1 down to 0.
- R4: Each entry averages blocks of 4 calibration samples of its own coarse code. On the 4th sample the entry becomes floor(sum/4), which is a truncating shift. Up to that point the previous average stays in use.
- R5: Until all K entries have completed at least one average, every output has `out_corrected`=0 and `out_data` = clamp(F - C*512), with F the 12-bit unsigned `in_fine` and C the `in_coarse`.
- R6: Once all entries are valid, every output has `out_corrected`=1 and `out_data` = clamp(F - T[C] + (8-C)*512 - 256).
- R7: clamp maps values below 0 to 0 and values above 4095 to 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Engine can accept a sample |
| in_cal | input | 1 | 1: sample is from the calibration column |
| in_coarse | input | COARSE_W (3) | Coarse segment code C |
| in_fine | input | COARSE_W+FINE_W (12) | Fine counter code F |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | OUT_W (12) | Corrected or uncorrected result |
| out_corrected | output | 1 | Result used the calibration table |

## Verification
The bench first drives ordinary samples into an empty table, where the plain two-step code must come out. It then starves one entry by a single sample, since a design that switched to correction on a partial table would emit corrected values there. It also sends three of four refresh samples to one entry and expects the old average to stay in use. The fourth sample is chosen so that rounding and truncation give different answers. Finally it covers both clamp limits, back-to-back samples that must produce back-to-back outputs, and a mid-run reset that must wipe the table.

// File: rtl/ofc_pkg.sv
package ofc_pkg;

    localparam int DEF_COARSE_W = 3;
    localparam int DEF_FINE_W   = 9;
    localparam int DEF_OUT_W    = 12;
    localparam int DEF_AVG_LOG2 = 2;

    typedef enum logic {
        SRC_GENERAL = 1'b0,
        SRC_CAL     = 1'b1
    } src_e;

    // Saturate a signed value into [0, hi].
    function automatic int sat_to_range(int v, int hi);
        if (v < 0)
            return 0;
        if (v > hi)
            return hi;
        return v;
    endfunction

    // Two-step code without calibration.
    function automatic int raw_code(int f, int c, int seg);
        return f - c * seg;
    endfunction

    // Code corrected with the calibration entry of the same segment.
    function automatic int corrected_code(int f, int tab, int c, int k, int seg);
        return f - tab + (k - c) * seg - seg / 2;
    endfunction

endpackage

// File: rtl/ofc_avg_entry.sv
module ofc_avg_entry #(
    parameter int CNT_W    = 12,
    parameter int AVG_LOG2 = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_en,
    input  logic [CNT_W-1:0] sample,
    output logic [CNT_W-1:0] entry,
    output logic             entry_valid
);
    localparam int ACC_W = CNT_W + AVG_LOG2;

    generate
        if (AVG_LOG2 == 0) begin : g_direct
            always_ff @(posedge clk) begin
                if (rst) begin
                    entry       <= '0;
                    entry_valid <= 1'b0;
                end else if (sample_en) begin
                    entry       <= sample;
                    entry_valid <= 1'b1;
                end
            end
        end else begin : g_block_avg
            logic [ACC_W-1:0]    acc;
            logic [AVG_LOG2-1:0] cnt;
            logic [ACC_W-1:0]    sum_next;

            always_comb sum_next = acc + ACC_W'(sample);

            always_ff @(posedge clk) begin
                if (rst) begin
                    acc         <= '0;
                    cnt         <= '0;
                    entry       <= '0;
                    entry_valid <= 1'b0;
                end else if (sample_en) begin
                    if (&cnt) begin
                        entry       <= sum_next[ACC_W-1:AVG_LOG2];
                        entry_valid <= 1'b1;
                        acc         <= '0;
                        cnt         <= '0;
                    end else begin
                        acc <= sum_next;
                        cnt <= cnt + AVG_LOG2'(1);
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/ofc_corrector.sv
module ofc_corrector
    import ofc_pkg::*;
#(
    parameter int COARSE_W = DEF_COARSE_W,
    parameter int FINE_W   = DEF_FINE_W,
    parameter int OUT_W    = DEF_OUT_W
) (
    input  logic [COARSE_W-1:0]        coarse,
    input  logic [COARSE_W+FINE_W-1:0] fine,
    input  logic [COARSE_W+FINE_W-1:0] tab_val,
    input  logic                       use_tab,
    output logic [OUT_W-1:0]           code
);
    localparam int K       = 1 << COARSE_W;
    localparam int SEG     = 1 << FINE_W;
    localparam int OUT_MAX = (1 << OUT_W) - 1;

    int unclamped;

    always_comb begin
        if (use_tab)
            unclamped = corrected_code(int'(fine), int'(tab_val), int'(coarse), K, SEG);
        else
            unclamped = raw_code(int'(fine), int'(coarse), SEG);
        code = OUT_W'(sat_to_range(unclamped, OUT_MAX));
    end
endmodule

// File: rtl/offset_cal_engine.sv
module offset_cal_engine
    import ofc_pkg::*;
#(
    parameter int COARSE_W = DEF_COARSE_W,
    parameter int FINE_W   = DEF_FINE_W,
    parameter int OUT_W    = DEF_OUT_W,
    parameter int AVG_LOG2 = DEF_AVG_LOG2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic                       in_cal,
    input  logic [COARSE_W-1:0]        in_coarse,
    input  logic [COARSE_W+FINE_W-1:0] in_fine,
    output logic                       out_valid,
    output logic [OUT_W-1:0]           out_data,
    output logic                       out_corrected
);
    localparam int K     = 1 << COARSE_W;
    localparam int CNT_W = COARSE_W + FINE_W;

    logic             ready_q;
    logic             accept;
    src_e             src;
    logic             take_cal;
    logic             take_gen;
    logic [CNT_W-1:0] tab [K];
    logic [K-1:0]     tab_valid;
    logic             table_full;
    logic [CNT_W-1:0] sel_entry;
    logic [OUT_W-1:0] code;

    always_comb begin
        src        = src_e'(in_cal);
        accept     = in_valid && ready_q;
        take_cal   = accept && (src == SRC_CAL);
        take_gen   = accept && (src == SRC_GENERAL);
        table_full = &tab_valid;
        sel_entry  = tab[in_coarse];
    end

    generate
        for (genvar e = 0; e < K; e++) begin : g_entry
            ofc_avg_entry #(
                .CNT_W   (CNT_W),
                .AVG_LOG2(AVG_LOG2)
            ) u_entry (
                .clk        (clk),
                .rst        (rst),
                .sample_en  (take_cal && (in_coarse == COARSE_W'(e))),
                .sample     (in_fine),
                .entry      (tab[e]),
                .entry_valid(tab_valid[e])
            );
        end
    endgenerate

    ofc_corrector #(
        .COARSE_W(COARSE_W),
        .FINE_W  (FINE_W),
        .OUT_W   (OUT_W)
    ) u_corr (
        .coarse (in_coarse),
        .fine   (in_fine),
        .tab_val(sel_entry),
        .use_tab(table_full),
        .code   (code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q       <= 1'b0;
            out_valid     <= 1'b0;
            out_data      <= '0;
            out_corrected <= 1'b0;
        end else begin
            ready_q   <= 1'b1;
            out_valid <= take_gen;
            if (take_gen) begin
                out_data      <= code;
                out_corrected <= table_full;
            end
        end
    end

    always_comb in_ready = ready_q;
endmodule

// File: rtl/ofc_checker.sv
module ofc_checker
    import ofc_pkg::*;
#(
    parameter int COARSE_W = DEF_COARSE_W,
    parameter int FINE_W   = DEF_FINE_W,
    parameter int OUT_W    = DEF_OUT_W,
    parameter int AVG_LOG2 = DEF_AVG_LOG2
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       in_valid,
    input logic                       in_ready,
    input logic                       in_cal,
    input logic [COARSE_W-1:0]        in_coarse,
    input logic [COARSE_W+FINE_W-1:0] in_fine,
    input logic                       out_valid,
    input logic [OUT_W-1:0]           out_data,
    input logic                       out_corrected
);
    localparam int K       = 1 << COARSE_W;
    localparam int SEG     = 1 << FINE_W;
    localparam int OUT_MAX = (1 << OUT_W) - 1;
    localparam int N       = 1 << AVG_LOG2;

    logic         gen_acc;
    logic         cal_acc;
    logic [K-1:0] seen_full;

    always_comb begin
        gen_acc = in_valid && in_ready && !in_cal;
        cal_acc = in_valid && in_ready && in_cal;
    end

    generate
        for (genvar e = 0; e < K; e++) begin : g_seen
            logic [AVG_LOG2:0] seen_cnt;
            always_ff @(posedge clk) begin
                if (rst)
                    seen_cnt <= '0;
                else if (cal_acc && in_coarse == COARSE_W'(e) && seen_cnt < (AVG_LOG2+1)'(N))
                    seen_cnt <= seen_cnt + 1'b1;
            end
            always_comb seen_full[e] = (seen_cnt == (AVG_LOG2+1)'(N));
        end
    endgenerate

    AST_OUT_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        gen_acc |=> out_valid);  // R2
    AST_NO_OUT_WITHOUT_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(gen_acc));  // R2
    AST_CAL_SILENT: assert property (@(posedge clk) disable iff (rst)
        cal_acc |=> !out_valid);  // R3
    AST_CORR_NEEDS_FULL_TABLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_corrected) |-> $past(&seen_full));  // R5
    AST_CORR_AFTER_FULL_TABLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_corrected) |-> !$past(&seen_full));  // R6
    AST_RAW_FORMULA: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_corrected) |->
            int'(out_data) == sat_to_range(raw_code(int'($past(in_fine)), int'($past(in_coarse)), SEG), OUT_MAX));  // R5
endmodule

bind offset_cal_engine ofc_checker #(
    .COARSE_W(COARSE_W),
    .FINE_W  (FINE_W),
    .OUT_W   (OUT_W),
    .AVG_LOG2(AVG_LOG2)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_cal       (in_cal),
    .in_coarse    (in_coarse),
    .in_fine      (in_fine),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .out_corrected(out_corrected)
);

// File: tb/offset_cal_engine_tb.sv
`timescale 1ns/1ps
module offset_cal_engine_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_cal = 1'b0;
    logic [2:0]  in_coarse = '0;
    logic [11:0] in_fine = '0;
    logic        out_valid;
    logic [11:0] out_data;
    logic        out_corrected;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Stimulus/expected vectors for a fully calibrated table T[c] = 3830 + 3*c.
    // Fields: coarse C, fine F, expected clamp(F - T[C] + (8-C)*512 - 256).
    localparam int NV = 8;
    localparam int VEC [NV][3] = '{
        '{7, 3600,    5},
        '{0, 4000, 4010},
        '{3, 3900, 2365},
        '{5, 3584, 1019},
        '{7, 3500,    0},   // below zero -> 0
        '{0, 4095, 4095},   // above range -> 4095
        '{2, 3700, 2680},
        '{6, 4050,  970}
    };

    offset_cal_engine u_dut (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_cal       (in_cal),
        .in_coarse    (in_coarse),
        .in_fine      (in_fine),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .out_corrected(out_corrected)
    );

    always #5 clk = ~clk;

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int cal_target(int c);
        return 3830 + 3 * c;
    endfunction

    task automatic send_cal(int c, int f);
        @(negedge clk);
        in_valid  = 1'b1;
        in_cal    = 1'b1;
        in_coarse = 3'(c);
        in_fine   = 12'(f);
        @(negedge clk);
        chk("R3 calibration sample gives no output", int'(out_valid), 0);
        in_valid = 1'b0;
    endtask

    task automatic send_gen(int c, int f, int exp, int corr, string req);
        @(negedge clk);
        in_valid  = 1'b1;
        in_cal    = 1'b0;
        in_coarse = 3'(c);
        in_fine   = 12'(f);
        @(negedge clk);
        chk({req, " out_valid"}, int'(out_valid), 1);
        chk({req, " out_data"}, int'(out_data), exp);
        chk({req, " out_corrected"}, int'(out_corrected), corr);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R2 out_valid lasts one cycle", int'(out_valid), 0);
    endtask

    // One pass of the test index m = 0..last; coarse code is 7-m.
    task automatic cal_round(int j, int last);
        for (int m = 0; m <= last; m++)
            send_cal(7 - m, cal_target(7 - m) - 1 + j);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state, a sample offered during reset is dropped
        @(negedge clk);
        in_valid = 1'b1;
        in_coarse = 3'd2;
        in_fine = 12'd3700;
        @(negedge clk);
        chk("R1 in_ready low in reset", int'(in_ready), 0);
        chk("R1 out_valid low in reset", int'(out_valid), 0);
        chk("R1 out_corrected low in reset", int'(out_corrected), 0);
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 in_ready high after reset", int'(in_ready), 1);
        chk("R1 no output after reset", int'(out_valid), 0);

        // R5 / R7: empty table gives plain two-step code
        send_gen(2, 3700, 2676, 0, "R5 uncorrected");
        send_gen(7, 3500, 0, 0, "R7 raw low clamp");

        // R3 / R4 / R5: three full rounds, fourth round misses entry 0
        for (int j = 0; j < 3; j++)
            cal_round(j, 7);
        cal_round(3, 6);
        send_gen(2, 3700, 2676, 0, "R5 one entry short");
        send_cal(0, cal_target(0) + 2);

        // R6 / R7: vector table
        for (int i = 0; i < NV; i++)
            send_gen(VEC[i][0], VEC[i][1], VEC[i][2], 1, $sformatf("R6/R7 vector %0d", i));

        // R2: back-to-back samples
        @(negedge clk);
        in_valid = 1'b1; in_cal = 1'b0; in_coarse = 3'd3; in_fine = 12'd3900;
        @(negedge clk);
        chk("R2 first of pair", int'(out_data), 2365);
        chk("R2 first of pair valid", int'(out_valid), 1);
        in_coarse = 3'd6; in_fine = 12'd4050;
        @(negedge clk);
        chk("R2 second of pair", int'(out_data), 970);
        chk("R2 second of pair valid", int'(out_valid), 1);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R2 pair ends", int'(out_valid), 0);

        // R4: refresh entry 3; old average holds until the 4th sample
        send_cal(3, 3900);
        send_cal(3, 3900);
        send_cal(3, 3900);
        send_gen(3, 3900, 2365, 1, "R4 old average held");
        send_cal(3, 3903);   // sum 15603 -> 3900 truncated
        send_gen(3, 3900, 2304, 1, "R4 truncated average");

        // R1: mid-run reset empties the table
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        send_gen(2, 3700, 2676, 0, "R1 reset clears table");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule